// File: doc/BRIEF.md
# Stoppable Programmable Clock Divider

The block derives one divided clock from one of several candidate input clocks. The whole design runs on a single reference clock. Each candidate input is given as a tick strobe in that domain. The divided output is a clock-enable pulse train: one reference cycle wide, and high once for every N ticks of the selected input, where N is the divide ratio.

Software reaches one 32-bit control register through a small write port. The register holds:
- a 6-bit divisor index at bits [5:0], where the ratio is the index plus one;
- a stop flag at bit 8;
- a 2-bit source selector at bits [13:12].

The 2-bit write address does not pick a register. It picks how a write changes the one register:
- 0: full update of all three fields;
- 1: divisor-only update;
- 2: halt/run command;
- 3: no effect.

A stop request is accepted only when the divisor is non-zero. For that reason the halt command also forces the divisor field to all ones when it stops the output.

A sequencer has three states: ST_HALT, ST_START and ST_RUN. It copies the written (pending) settings into the active settings at only two moments: on leaving ST_HALT, and at the end of an output period. A changed ratio, source or stop therefore never shortens a period.

The transitions are:
- ST_HALT → ST_START once the pending stop flag is clear;
- ST_START → ST_RUN always, after loading the active settings and clearing the tick counter;
- ST_RUN → ST_RUN at each period end while no stop is pending, reloading the settings;
- ST_RUN → ST_HALT at a period end while a stop is pending.

Top module: `stop_clk_div`

## Requirements
- R1: With active divisor index D, `clk_en_o` is high for one reference cycle after every D+1 ticks of the selected source. With index 0 and a source that ticks every cycle, the output is high on every cycle.
- R2: The selector at bits [13:12] picks `src_tick_i[sel]`. Only ticks of that input advance the divider, so a source ticking every k cycles gives a period of k·(D+1) cycles.
- R3: A full-update write (address 0) whose selector value is 3 or more sets `src_err_o` from the next cycle and leaves the selected source unchanged. A full-update write with a selector of 0 to 2 clears `src_err_o`.
- R4: While the stop flag is set and the current period has ended, `clk_en_o` stays low. Clearing the flag restarts the output.
- R5: In a full-update write, a stop request (bit 8 = 1) is ignored when the written divisor field is 0. The stop flag reads 0 afterwards and the output keeps running.
- R6: A halt command (address 2, bit 8 = 1) sets the stop flag and forces the divisor to 63, so that readback is 0x0000013F once halted. A halt command with bit 8 = 0 clears the stop flag.
- R7: A divisor-only write (address 1) changes the divisor field and keeps the stop flag, the selector and the error flag.
- R8: A new divisor, source or stop takes effect only at the end of the period in progress. The period that is running when the change is written keeps its old length.
- R9: Readback `bus_rdata` returns the active divisor at [5:0], the stop flag at bit 8 and the active selector at [13:12], with all other bits 0. The divisor field changes only when the new ratio is in use.
- R10: After reset, readback is 0x0000013F (ratio 64, stopped, source 0), and `clk_en_o` and `src_err_o` are low.
- R11: A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick_i | input | NUM_SRC | Tick strobes of the candidate input clocks |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Write mode: 0 full, 1 divisor only, 2 halt/run, 3 none |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Control register readback |
| clk_en_o | output | 1 | Divided clock as an enable pulse |
| src_err_o | output | 1 | Invalid source selector flag |

## Verification
The bound checker watches every cycle for the following:
- the error flag reacting to each full-update write, with the source kept on an invalid selector;
- a stop request being refused when the written divisor is zero;
- the halt command forcing the divisor;
- silence while halted;
- writes to address 3 changing nothing;
- the active divisor changing only in the cycle that carries a period-end pulse.

The following only the bench scenarios can show:
- the exact spacing of pulses for each ratio and source;
- that the period running during a ratio or stop change keeps its full old length;
- the readback values as seen from outside the block.

// File: rtl/cdv_pkg.sv
package cdv_pkg;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_START = 2'd1,
        ST_RUN   = 2'd2
    } div_state_t;

    typedef enum logic [1:0] {
        WM_FULL = 2'd0,
        WM_DIV  = 2'd1,
        WM_HALT = 2'd2,
        WM_NONE = 2'd3
    } wr_mode_t;

endpackage

// File: rtl/cdv_ctrl_reg.sv
module cdv_ctrl_reg
    import cdv_pkg::*;
#(
    parameter int REG_W     = 32,
    parameter int DIV_W     = 6,
    parameter int DIV_SHIFT = 0,
    parameter int STOP_POS  = 8,
    parameter int SRC_W     = 2,
    parameter int SRC_SHIFT = 12,
    parameter int NUM_SRC   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wdata,
    output logic [DIV_W-1:0] pend_div,
    output logic             pend_stop,
    output logic [SRC_W-1:0] pend_src,
    output logic             src_err
);

    localparam logic [DIV_W-1:0] DIV_ALL_ONES = {DIV_W{1'b1}};

    logic [DIV_W-1:0] w_div;
    logic             w_stop;
    logic [SRC_W-1:0] w_src;
    logic             w_src_ok;
    wr_mode_t         mode;

    assign w_div    = wdata[DIV_SHIFT +: DIV_W];
    assign w_stop   = wdata[STOP_POS];
    assign w_src    = wdata[SRC_SHIFT +: SRC_W];
    assign w_src_ok = (int'(w_src) < NUM_SRC);
    assign mode     = wr_mode_t'(addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_div  <= DIV_ALL_ONES;
            pend_stop <= 1'b1;
            pend_src  <= '0;
            src_err   <= 1'b0;
        end else if (we) begin
            unique case (mode)
                WM_FULL: begin
                    pend_div  <= w_div;
                    pend_stop <= w_stop && (w_div != '0);
                    if (w_src_ok) begin
                        pend_src <= w_src;
                    end
                    src_err <= !w_src_ok;
                end
                WM_DIV: begin
                    pend_div <= w_div;
                end
                WM_HALT: begin
                    if (w_stop) begin
                        pend_stop <= 1'b1;
                        pend_div  <= DIV_ALL_ONES;
                    end else begin
                        pend_stop <= 1'b0;
                    end
                end
                WM_NONE: begin
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/cdv_src_mux.sv
module cdv_src_mux #(
    parameter int NUM_SRC = 3,
    parameter int SRC_W   = 2
) (
    input  logic [NUM_SRC-1:0] src_tick_i,
    input  logic [SRC_W-1:0]   sel,
    output logic               tick
);

    logic [NUM_SRC-1:0] hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign hit[i] = src_tick_i[i] && (sel == SRC_W'(i));
    end

    assign tick = |hit;

endmodule

// File: rtl/cdv_div_fsm.sv
module cdv_div_fsm
    import cdv_pkg::*;
#(
    parameter int DIV_W = 6,
    parameter int SRC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [DIV_W-1:0] pend_div,
    input  logic             pend_stop,
    input  logic [SRC_W-1:0] pend_src,
    output logic [DIV_W-1:0] act_div,
    output logic [SRC_W-1:0] act_src,
    output logic             clk_en,
    output div_state_t       state_o
);

    div_state_t       state_q, state_d;
    logic [DIV_W-1:0] cnt_q;
    logic             load;
    logic             out_d;
    logic             period_end;

    assign period_end = tick && (cnt_q == act_div);
    assign state_o    = state_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        out_d   = 1'b0;
        unique case (state_q)
            ST_HALT: begin
                if (!pend_stop) begin
                    state_d = ST_START;
                end
            end
            ST_START: begin
                load    = 1'b1;
                state_d = ST_RUN;
            end
            ST_RUN: begin
                if (period_end) begin
                    out_d = 1'b1;
                    load  = 1'b1;
                    if (pend_stop) begin
                        state_d = ST_HALT;
                    end
                end
            end
            default: begin
                state_d = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            act_div <= {DIV_W{1'b1}};
            act_src <= '0;
            clk_en  <= 1'b0;
        end else begin
            clk_en <= out_d;
            if (load) begin
                cnt_q   <= '0;
                act_div <= pend_div;
                act_src <= pend_src;
            end else if (state_q == ST_RUN && tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/stop_clk_div.sv
module stop_clk_div
    import cdv_pkg::*;
#(
    parameter int REG_W     = 32,
    parameter int DIV_W     = 6,
    parameter int DIV_SHIFT = 0,
    parameter int STOP_POS  = 8,
    parameter int SRC_W     = 2,
    parameter int SRC_SHIFT = 12,
    parameter int NUM_SRC   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick_i,
    input  logic               bus_we,
    input  logic [1:0]         bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    output logic               clk_en_o,
    output logic               src_err_o
);

    logic [DIV_W-1:0] pend_div;
    logic             pend_stop;
    logic [SRC_W-1:0] pend_src;
    logic [DIV_W-1:0] act_div;
    logic [SRC_W-1:0] act_src;
    logic             sel_tick;
    div_state_t       fsm_state;

    cdv_ctrl_reg #(
        .REG_W(REG_W), .DIV_W(DIV_W), .DIV_SHIFT(DIV_SHIFT), .STOP_POS(STOP_POS),
        .SRC_W(SRC_W), .SRC_SHIFT(SRC_SHIFT), .NUM_SRC(NUM_SRC)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .pend_div(pend_div), .pend_stop(pend_stop), .pend_src(pend_src),
        .src_err(src_err_o)
    );

    cdv_src_mux #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_mux (
        .src_tick_i(src_tick_i), .sel(act_src), .tick(sel_tick)
    );

    cdv_div_fsm #(.DIV_W(DIV_W), .SRC_W(SRC_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(sel_tick),
        .pend_div(pend_div), .pend_stop(pend_stop), .pend_src(pend_src),
        .act_div(act_div), .act_src(act_src), .clk_en(clk_en_o), .state_o(fsm_state)
    );

    always_comb begin
        bus_rdata                         = '0;
        bus_rdata[DIV_SHIFT +: DIV_W]     = act_div;
        bus_rdata[STOP_POS]               = pend_stop;
        bus_rdata[SRC_SHIFT +: SRC_W]     = act_src;
    end

endmodule

// File: rtl/stop_clk_div_chk.sv
module stop_clk_div_chk
    import cdv_pkg::*;
#(
    parameter int REG_W     = 32,
    parameter int DIV_W     = 6,
    parameter int DIV_SHIFT = 0,
    parameter int STOP_POS  = 8,
    parameter int SRC_W     = 2,
    parameter int SRC_SHIFT = 12,
    parameter int NUM_SRC   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [1:0]       bus_addr,
    input logic [REG_W-1:0] bus_wdata,
    input logic [REG_W-1:0] bus_rdata,
    input logic             clk_en_o,
    input logic             src_err_o,
    input logic [DIV_W-1:0] pend_div,
    input logic             pend_stop,
    input logic [SRC_W-1:0] pend_src,
    input logic [DIV_W-1:0] act_div,
    input logic [SRC_W-1:0] act_src,
    input div_state_t       fsm_state
);

    logic             wr_full;
    logic [SRC_W-1:0] w_src;
    logic [DIV_W-1:0] w_div;

    assign wr_full = bus_we && (bus_addr == 2'd0);
    assign w_src   = bus_wdata[SRC_SHIFT +: SRC_W];
    assign w_div   = bus_wdata[DIV_SHIFT +: DIV_W];

    AST_BAD_SRC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wr_full && (int'(w_src) >= NUM_SRC) |=> src_err_o && (pend_src == $past(pend_src))); // R3
    AST_GOOD_SRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_full && (int'(w_src) < NUM_SRC) |=> !src_err_o); // R3
    AST_STOP_NEEDS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        wr_full && bus_wdata[STOP_POS] && (w_div == '0) |=> !bus_rdata[STOP_POS]); // R5
    AST_HALT_FORCES_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && (bus_addr == 2'd2) && bus_wdata[STOP_POS] |=> pend_stop && (pend_div == {DIV_W{1'b1}})); // R6
    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_HALT) && ($past(fsm_state) == ST_HALT) |-> !clk_en_o); // R4
    AST_SWITCH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fsm_state) == ST_RUN) && (act_div != $past(act_div)) |-> clk_en_o); // R8
    AST_NONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && (bus_addr == 2'd3) |=> $stable(pend_div) && $stable(pend_stop) && $stable(pend_src)); // R11
    AST_SRC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(act_src) < NUM_SRC); // R2

endmodule

bind stop_clk_div stop_clk_div_chk #(
    .REG_W(REG_W), .DIV_W(DIV_W), .DIV_SHIFT(DIV_SHIFT), .STOP_POS(STOP_POS),
    .SRC_W(SRC_W), .SRC_SHIFT(SRC_SHIFT), .NUM_SRC(NUM_SRC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_en_o(clk_en_o),
    .src_err_o(src_err_o), .pend_div(pend_div), .pend_stop(pend_stop),
    .pend_src(pend_src), .act_div(act_div), .act_src(act_src), .fsm_state(fsm_state)
);

// File: tb/stop_clk_div_tb.sv
`timescale 1ns/1ps
module stop_clk_div_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ticks = 3'b001;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        clk_en_o;
    logic        src_err_o;

    int    n_chk = 0, n_fail = 0;
    int    cyc = 0, tcnt = 0;
    int    exp_q[$];
    bit    restart = 1'b0;
    int    last_pulse = 0;
    int    n_pulse = 0;
    bit    done = 1'b0;
    string sb_tag = "R1";

    always #2 clk = ~clk;

    stop_clk_div u_dut (
        .clk(clk), .rst_n(rst_n), .src_tick_i(ticks), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .clk_en_o(clk_en_o), .src_err_o(src_err_o)
    );

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        tcnt++;
        ticks[1] = ~ticks[1];
        ticks[2] = (tcnt % 3 == 0);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor: compares pulse spacing with queued expectations
    always @(negedge clk) begin
        if (rst_n && clk_en_o) begin
            n_pulse++;
            if (restart) begin
                restart = 1'b0;
            end else if (exp_q.size() > 0) begin
                int e;
                e = exp_q.pop_front();
                check((cyc - last_pulse) == e, {sb_tag, " pulse gap"}, cyc - last_pulse, e);
            end
            last_pulse = cyc;
        end
    end

    function automatic logic [31:0] fld(input int div, input int stp, input int src);
        return 32'(div) | (32'(stp) << 8) | (32'(src) << 12);
    endfunction

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    endtask

    task automatic wait_pulse();
        @(negedge clk);
        while (!clk_en_o) @(negedge clk);
        #1;
    endtask

    task automatic wait_drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic push(input int gap, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(gap);
    endtask

    task automatic run_case(input int div, input int src, input int gap, input string tag);
        bus_wr(2'd2, fld(0, 1, 0));
        repeat (260) @(negedge clk);
        restart = 1'b1;
        sb_tag  = tag;
        push(gap, 3);
        bus_wr(2'd0, fld(div, 0, src));
        wait_drain();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R8 watchdog: actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int p;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_rdata == 32'h13F, "R10 reset readback", bus_rdata, 32'h13F);
        check(clk_en_o == 1'b0, "R10 reset output", clk_en_o, 0);
        check(src_err_o == 1'b0, "R10 reset error flag", src_err_o, 0);
        repeat (100) @(negedge clk);
        check(n_pulse == 0, "R4 no pulses while stopped", n_pulse, 0);

        // R11: address 3 must not touch anything
        bus_wr(2'd3, 32'h0);
        check(bus_rdata == 32'h13F, "R11 readback after mode 3", bus_rdata, 32'h13F);
        repeat (50) @(negedge clk);
        check(n_pulse == 0, "R11 still stopped", n_pulse, 0);

        run_case(0, 0, 1, "R1");
        run_case(2, 1, 6, "R2");
        run_case(4, 2, 15, "R2");
        run_case(63, 0, 64, "R1");
        run_case(3, 0, 4, "R8");

        // R8/R7/R9: divisor change mid-period keeps current period length
        wait_pulse();
        sb_tag = "R8";
        exp_q.push_back(4); push(2, 3);
        bus_wr(2'd1, fld(1, 0, 0));
        check(bus_rdata[5:0] == 6'd3, "R9 old divisor before boundary", bus_rdata[5:0], 3);
        check(bus_rdata[8] == 1'b0, "R7 stop kept", bus_rdata[8], 0);
        check(bus_rdata[13:12] == 2'd0, "R7 source kept", bus_rdata[13:12], 0);
        wait_drain();
        check(bus_rdata[5:0] == 6'd1, "R9 new divisor after boundary", bus_rdata[5:0], 1);

        // R5: stop ignored with zero divisor
        wait_pulse();
        sb_tag = "R5";
        exp_q.push_back(2); push(1, 3);
        bus_wr(2'd0, fld(0, 1, 0));
        check(bus_rdata[8] == 1'b0, "R5 stop flag refused", bus_rdata[8], 0);
        wait_drain();

        // R6: halt command forces divisor and stops
        wait_pulse();
        bus_wr(2'd2, fld(0, 1, 0));
        repeat (5) @(negedge clk);
        p = n_pulse;
        repeat (200) @(negedge clk);
        check(n_pulse == p, "R6 halted output silent", n_pulse - p, 0);
        check(bus_rdata == 32'h13F, "R6 halted readback", bus_rdata, 32'h13F);

        // R3: invalid selector
        restart = 1'b1;
        sb_tag = "R3";
        push(3, 3);
        bus_wr(2'd0, fld(2, 0, 3));
        check(src_err_o == 1'b1, "R3 error raised", src_err_o, 1);
        check(bus_rdata[13:12] == 2'd0, "R3 source unchanged", bus_rdata[13:12], 0);
        wait_drain();

        // R4: stop through a full write with non-zero divisor
        bus_wr(2'd0, fld(2, 1, 0));
        repeat (10) @(negedge clk);
        p = n_pulse;
        repeat (100) @(negedge clk);
        check(n_pulse == p, "R4 stopped by full write", n_pulse - p, 0);
        restart = 1'b1;
        sb_tag = "R4";
        push(3, 2);
        bus_wr(2'd0, fld(2, 0, 0));
        wait_drain();

        run_case(1, 2, 6, "R3");
        check(src_err_o == 1'b0, "R3 error cleared by valid write", src_err_o, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule